// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Core

This is a 32-bit processor core that completes one instruction per clock. It fetches a word from an external instruction memory, decodes it, reads up to two operands from a 32-entry register file, runs the operation through an ALU, and in the same cycle either writes a result back, stores a word to data memory, or changes the program counter. Both memories sit outside the core. They are reached through plain address and data ports, and the bench indexes them by word using address bits [9:2]. The data memory is expected to answer a read combinationally within the cycle.

Nine operations are executed: word load and store, register add, subtract, AND, OR and signed set-less-than, branch-if-equal, and an absolute jump. Any other opcode writes nothing and simply advances the program counter by four. The ALU operation is chosen in two levels. The main decoder classifies the instruction, and for register-format instructions a second decoder then reads the function field.

Top module: `nine_op_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes RESET_PC (default 0) and all 32 registers become 0. The PC is seen on `imem_addr`.
- R2: A load (opcode 100011, base rs in [25:21], destination rt in [20:16], immediate in [15:0]) drives `dmem_addr` = rs + sign-extended immediate and raises `dmem_rd`. It writes `dmem_rdata` into rt. `dmem_rd` is low for every other instruction.
- R3: A store (opcode 101011) drives `dmem_addr` = rs + sign-extended immediate, `dmem_wdata` = rt, `dmem_wr` = 1 and `dmem_mask` = 1111. It writes no register. `dmem_wr` is low for every other instruction.
- R4: Register-format instructions (opcode 000000, rd in [15:11], function in [5:0]) write rd with rs+rt for 100000, rs-rt for 100010, rs AND rt for 100100 and rs OR rt for 100101.
- R5: Function 101010 writes 1 to rd when rs < rt as signed two's-complement values, and 0 otherwise.
- R6: A branch-if-equal (opcode 000100) whose registers rs and rt are equal sets the next PC to PC+4 + (sign-extended immediate << 2). This holds for forward and backward offsets. When they differ, the next PC is PC+4. The branch writes no register.
- R7: A jump (opcode 000010) sets the next PC to {PC[31:28], bits [25:0], 00} and writes no register.
- R8: A write aimed at register 0 has no effect, so register 0 always reads 0.
- R9: Every non-branching instruction advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Address of the instruction being fetched (the PC) |
| imem_word | input | 32 | Instruction word returned by instruction memory |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe |
| dmem_mask | output | 4 | Byte write mask |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data returned by data memory |

## Verification
The bench builds the core with the default RESET_PC of 0, so the jump keeps the upper PC bits at zero, and every address stays inside a 256-word model indexed by bits [9:2]. A single program covers the following:
- a taken forward branch over two stores that must not happen;
- a not-taken branch;
- a negative load/store displacement;
- a jump over two more stores;
- a backward branch that holds the PC in place.

Signed and unsigned comparison are separated by comparing -5 with 5 in both orders. Stores and branches that wrongly write their rt register are exposed because that register is read again immediately afterwards. A register that is never written is stored at the end to show that reset cleared it.

// File: rtl/nine_op_core.sv
module nine_op_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_word,
  output logic [31:0] dmem_addr,
  output logic        dmem_rd,
  output logic        dmem_wr,
  output logic [3:0]  dmem_mask,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata
);
  localparam int NREG = 32;

  logic [31:0] pc;
  logic [31:0] regs [NREG];

  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, wsel;
  logic [15:0] imm;
  logic [25:0] jfield;
  logic [31:0] simm, opa, opb, alu_b, alu_y, wval;
  logic [31:0] pc_inc, pc_br, pc_jmp, pc_next;
  logic        reg_dst, alu_imm, mem_to_reg, reg_we, mem_rd, mem_wr, is_br, is_jmp;
  logic [1:0]  alu_op;
  logic [3:0]  alu_code;
  logic        zero, take_br;
  logic        unused_bits;

  assign opcode = imem_word[31:26];
  assign rs     = imem_word[25:21];
  assign rt     = imem_word[20:16];
  assign rd     = imem_word[15:11];
  assign funct  = imem_word[5:0];
  assign imm    = imem_word[15:0];
  assign jfield = imem_word[25:0];
  assign unused_bits = ^imem_word[10:6];

  assign simm = {{16{imm[15]}}, imm};

  always_comb begin
    reg_dst = 1'b0; alu_imm = 1'b0; mem_to_reg = 1'b0; reg_we = 1'b0;
    mem_rd = 1'b0; mem_wr = 1'b0; is_br = 1'b0; is_jmp = 1'b0; alu_op = 2'b00;
    case (opcode)
      6'b000000: begin reg_dst = 1'b1; reg_we = 1'b1; alu_op = 2'b10; end
      6'b100011: begin alu_imm = 1'b1; mem_to_reg = 1'b1; reg_we = 1'b1; mem_rd = 1'b1; end
      6'b101011: begin alu_imm = 1'b1; mem_wr = 1'b1; end
      6'b000100: begin is_br = 1'b1; alu_op = 2'b01; end
      6'b000010: is_jmp = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b00: alu_code = 4'b0010;
      2'b01: alu_code = 4'b0110;
      default: begin
        case (funct)
          6'b100000: alu_code = 4'b0010;
          6'b100010: alu_code = 4'b0110;
          6'b100100: alu_code = 4'b0000;
          6'b100101: alu_code = 4'b0001;
          6'b101010: alu_code = 4'b0111;
          default:   alu_code = 4'b1111;
        endcase
      end
    endcase
  end

  assign opa   = regs[rs];
  assign opb   = regs[rt];
  assign alu_b = alu_imm ? simm : opb;

  always_comb begin
    case (alu_code)
      4'b0000: alu_y = opa & alu_b;
      4'b0001: alu_y = opa | alu_b;
      4'b0010: alu_y = opa + alu_b;
      4'b0110: alu_y = opa - alu_b;
      4'b0111: alu_y = {31'd0, $signed(opa) < $signed(alu_b)};
      default: alu_y = 32'd0;
    endcase
  end

  assign zero = (alu_y == 32'd0);

  wire func_ok = (alu_op != 2'b10) || (alu_code != 4'b1111);
  assign wsel = reg_dst ? rd : rt;
  assign wval = mem_to_reg ? dmem_rdata : alu_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 32'd0;
    end else if (reg_we && func_ok && wsel != 5'd0) begin
      regs[wsel] <= wval;
    end
  end

  assign pc_inc  = pc + 32'd4;
  assign pc_br   = pc_inc + {simm[29:0], 2'b00};
  assign pc_jmp  = {pc[31:28], jfield, 2'b00};
  assign take_br = is_br & zero;
  assign pc_next = is_jmp ? pc_jmp : (take_br ? pc_br : pc_inc);

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_rd    = mem_rd;
  assign dmem_wr    = mem_wr;
  assign dmem_mask  = mem_wr ? 4'b1111 : 4'b0000;
  assign dmem_wdata = opb;
endmodule

// File: rtl/nine_op_core_chk.sv
module nine_op_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_word,
  input logic        dmem_rd,
  input logic        dmem_wr,
  input logic [3:0]  dmem_mask,
  input logic [31:0] r0_val
);
  wire [5:0] op = imem_word[31:26];

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> imem_addr == RESET_PC);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));

  assert_store_mask_R3: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> dmem_mask == 4'b1111);

  assert_load_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    dmem_rd |-> op == 6'b100011);

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 6'b000010) |->
      imem_addr == {$past(imem_addr[31:28]), $past(imem_word[25:0]), 2'b00});

  assert_seq_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op) == 6'b000000 || $past(op) == 6'b100011 || $past(op) == 6'b101011))
      |-> imem_addr == $past(imem_addr) + 32'd4);

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
    r0_val == 32'd0);
endmodule

bind nine_op_core nine_op_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_word(imem_word),
  .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_mask(dmem_mask), .r0_val(regs[0])
);

// File: tb/sim_nine_op_core.sv
`timescale 1ns/1ps
module sim_nine_op_core;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] imem_addr, imem_word, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_rd, dmem_wr;
  logic [3:0] dmem_mask;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] pc_q [$];
  logic [63:0] st_q [$];

  always #4 clk = ~clk;

  nine_op_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_word(imem_word),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_mask(dmem_mask), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  assign imem_word  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk)
    if (dmem_wr) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] r_op(input int s, input int t, input int d, input logic [5:0] f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] i_op(input logic [5:0] o, input int s, input int t, input logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction

  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_pc(input int idx);
    pc_q.push_back(32'(idx * 4));
  endtask
  task automatic push_store(input logic [31:0] a, input logic [31:0] d);
    st_q.push_back({a, d});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
    dmem[0] = 32'd5; dmem[1] = 32'd5;
    dmem[8] = 32'h0F0F00FF; dmem[9] = 32'h00FF0F0F;
    imem[0]  = i_op(LW, 0, 8, 16'd0);
    imem[1]  = i_op(LW, 0, 9, 16'd4);
    imem[2]  = i_op(BEQ, 8, 9, 16'd2);
    imem[3]  = i_op(SW, 0, 8, 16'd100);
    imem[4]  = i_op(SW, 0, 8, 16'd104);
    imem[5]  = r_op(8, 9, 10, 6'b100000);
    imem[6]  = i_op(SW, 0, 10, 16'd12);
    imem[7]  = r_op(8, 10, 11, 6'b100010);
    imem[8]  = i_op(SW, 0, 11, 16'd16);
    imem[9]  = i_op(LW, 0, 12, 16'd32);
    imem[10] = i_op(LW, 0, 13, 16'd36);
    imem[11] = r_op(12, 13, 14, 6'b100100);
    imem[12] = i_op(SW, 0, 14, 16'd20);
    imem[13] = r_op(12, 13, 15, 6'b100101);
    imem[14] = i_op(SW, 0, 15, 16'd24);
    imem[15] = r_op(11, 8, 16, 6'b101010);
    imem[16] = i_op(SW, 0, 16, 16'd28);
    imem[17] = r_op(8, 11, 17, 6'b101010);
    imem[18] = i_op(SW, 0, 17, 16'd40);
    imem[19] = r_op(8, 9, 0, 6'b100000);
    imem[20] = i_op(SW, 0, 0, 16'd44);
    imem[21] = i_op(BEQ, 8, 10, 16'd5);
    imem[22] = r_op(10, 10, 19, 6'b100000);
    imem[23] = i_op(SW, 19, 8, 16'hFFF8);
    imem[24] = {6'b000010, 26'd27};
    imem[25] = i_op(SW, 0, 8, 16'd200);
    imem[26] = i_op(SW, 0, 8, 16'd204);
    imem[27] = i_op(SW, 0, 8, 16'd52);
    imem[28] = i_op(SW, 0, 20, 16'd56);
    imem[29] = i_op(BEQ, 0, 0, 16'hFFFF);

    push_pc(0); push_pc(1); push_pc(2);
    for (int i = 5; i <= 24; i++) push_pc(i);
    push_pc(27); push_pc(28);
    for (int i = 0; i < 6; i++) push_pc(29);

    push_store(32'd12, 32'd10);
    push_store(32'd16, 32'hFFFFFFFB);
    push_store(32'd20, 32'h000F000F);
    push_store(32'd24, 32'h0FFF0FFF);
    push_store(32'd28, 32'd1);
    push_store(32'd40, 32'd0);
    push_store(32'd44, 32'd0);
    push_store(32'd12, 32'd5);
    push_store(32'd52, 32'd5);
    push_store(32'd56, 32'd0);
  end

  initial begin
    logic [31:0] epc;
    logic [63:0] est;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 pc after reset", imem_addr, 32'd0);
    check("R3 no write strobe after reset", {31'd0, dmem_wr}, 32'd0);
    while (pc_q.size() > 0) begin
      epc = pc_q.pop_front();
      check("R6/R7/R9 pc trace", imem_addr, epc);
      check("R2 read strobe only on load", {31'd0, dmem_rd}, {31'd0, imem_word[31:26] == LW});
      if (dmem_wr) begin
        if (st_q.size() == 0) begin
          check("R3/R6/R7 unexpected store address", dmem_addr, 32'hFFFFFFFF);
        end else begin
          est = st_q.pop_front();
          check("R2/R3 store address", dmem_addr, est[63:32]);
          check("R1/R4/R5/R8 store data", dmem_wdata, est[31:0]);
          check("R3 store mask", {28'd0, dmem_mask}, 32'hF);
        end
      end
      @(negedge clk);
    end
    check("R3 all stores seen", 32'(st_q.size()), 32'd0);
    check("R3 memory after negative offset", dmem[3], 32'd5);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule